// File: doc/BRIEF.md
# Bridge Control Register File

This block holds the control and status words of a host-to-PCI bridge: power-on and general configuration, device and memory timing, address-map control, GPIO, interrupt steering, four mailboxes, cache control and memory sizing. A processor-side agent reaches the words through a plain word-wide bus with an address, a write strobe with its data, and a read strobe. Every access moves one full 32-bit word, and each word comes out of reset with its own value.

Most words are plain storage. The interrupt-enable word cannot be written directly. It changes only through two alias words: one ORs the written bits into it and one clears them. The enable word and the interrupt-status word are read-only. Raising the self-reset bit of the general-configuration word makes the block issue a single-cycle system reset request.

The bus has no back-pressure. Every strobe is taken in the cycle it is presented, there is no ready signal, and the agent must not expect to be stalled. Read data is registered.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: The word index is the byte address shifted right by two, and address bits 1:0 are ignored. Indices 0 to 27 (byte offsets 0x00 to 0x6C) are implemented, and every access is a full 32-bit word.
- R2: After reset, the words read as follows:
  - offset 0x00: 0x00000C40
  - offset 0x04: 0x00001384 (bits 2, 7, 8, 9 and 12 set)
  - offset 0x08: 0x2BFF8010
  - offset 0x0C: 0x255E0091
  - offset 0x10: 0x00006140
  - offsets 0x1C and 0x20: 0x000001FF
  - offset 0x68: 0x00000008
  - offset 0x6C: 0x10000000
  - every other implemented word: 0.
- R3: A write to any plain word stores the whole value, and a later read of that word returns it. The plain words are every implemented offset except 0x30, 0x34, 0x38 and 0x3C.
- R4: A write to offset 0x30 stores the value at 0x30 and ORs it into the enable word at 0x38.
- R5: A write to offset 0x34 stores the value at 0x34 and clears the written one-bits in the enable word at 0x38.
- R6: Writes to offset 0x38 (enable) and 0x3C (interrupt status) change nothing. The status word reads 0.
- R7: Writes to offsets 0x70 to 0x7C change no word, and reads of those offsets return 0.
- R8: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. A read and a write to the same word in one cycle return the value held before the write.
- R9: A write to offset 0x04 that takes bit 2 from 0 to 1 drives `sys_rst_req` high in the cycle after the write. A write that leaves bit 2 at 1, or that writes it as 0, does not.
- R10: `sys_rst_req` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (7) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Registered read data |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Plain words get several kinds of data: all ones, zero, and alternating and mixed bit patterns. These show whether every bit is stored and whether each word lands at its own index. An address with nonzero low bits shows whether those bits are dropped. A sequence of set and clear writes with overlapping masks separates OR and AND-NOT behaviour from plain overwrite. A follow-up write to the enable word shows whether its read-only protection holds. The self-reset bit is driven through three writes: 1 over 1, then 0, then 0-to-1. Together these separate edge detection from level detection, and the bench also checks that the pulse lasts exactly one cycle.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  typedef enum logic [1:0] {K_PLAIN, K_ENSET_OR_CLR, K_EN, K_RO} kind_e;

  localparam int IDX_GENCFG   = 1;
  localparam int IDX_ENSET    = 12;
  localparam int IDX_ENCLR    = 13;
  localparam int IDX_EN       = 14;
  localparam int IDX_STAT     = 15;
  localparam int SELF_RST_BIT = 2;

  function automatic kind_e word_kind(input int i);
    case (i)
      IDX_EN:   return K_EN;
      IDX_STAT: return K_RO;
      default:  return K_PLAIN;
    endcase
  endfunction

  function automatic logic [31:0] word_reset(input int i);
    case (i)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7, 8:    return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode #(
  parameter int ADDR_W    = 7,
  parameter int NUM_WORDS = 28,
  localparam int IDX_W    = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  output logic [IDX_W-1:0]     idx,
  output logic                 hit,
  output logic [NUM_WORDS-1:0] wr_sel
);
  assign idx = addr[ADDR_W-1:2];
  assign hit = ({1'b0, idx} < (IDX_W+1)'(NUM_WORDS));

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
    assign wr_sel[i] = wr && hit && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/bcr_regs.sv
module bcr_regs
  import bcr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WORDS-1:0] wr_sel,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    q [NUM_WORDS]
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam kind_e KIND = word_kind(i);
    localparam logic [DATA_W-1:0] RST = DATA_W'(word_reset(i));
    logic [DATA_W-1:0] word_q;

    if (KIND == K_EN) begin : g_en
      always_ff @(posedge clk) begin
        if (!rst_n)                 word_q <= RST;
        else if (wr_sel[IDX_ENSET]) word_q <= word_q | wdata;
        else if (wr_sel[IDX_ENCLR]) word_q <= word_q & ~wdata;
      end
    end else if (KIND == K_RO) begin : g_ro
      assign word_q = RST;
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)        word_q <= RST;
        else if (wr_sel[i]) word_q <= wdata;
      end
    end
    assign q[i] = word_q;
  end
endmodule

// File: rtl/bcr_selfrst.sv
module bcr_selfrst (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic old_bit,
  input  logic new_bit,
  output logic req
);
  always_ff @(posedge clk) begin
    if (!rst_n) req <= 1'b0;
    else        req <= wr_hit && !old_bit && new_bit;
  end
endmodule

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs
  import bcr_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst_req
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]     idx;
  logic                 hit;
  logic [NUM_WORDS-1:0] wr_sel;
  logic [DATA_W-1:0]    regs_q [NUM_WORDS];
  logic [DATA_W-1:0]    en_q;

  bcr_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .idx(idx), .hit(hit), .wr_sel(wr_sel)
  );

  bcr_regs #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(bus_wdata), .q(regs_q)
  );

  bcr_selfrst u_srst (
    .clk(clk), .rst_n(rst_n),
    .wr_hit(wr_sel[IDX_GENCFG]),
    .old_bit(regs_q[IDX_GENCFG][SELF_RST_BIT]),
    .new_bit(bus_wdata[SELF_RST_BIT]),
    .req(sys_rst_req)
  );

  assign en_q = regs_q[IDX_EN];

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= hit ? regs_q[idx] : '0;
  end
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker
  import bcr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              sys_rst_req,
  input logic [DATA_W-1:0] en_q
);
  logic [ADDR_W-3:0] widx;
  assign widx = bus_addr[ADDR_W-1:2];

  a_r4_set_bits_on: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == (ADDR_W-2)'(IDX_ENSET)) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

  a_r5_clr_bits_off: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == (ADDR_W-2)'(IDX_ENCLR)) |=> ((en_q & $past(bus_wdata)) == '0));

  a_r6_enable_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == (ADDR_W-2)'(IDX_EN)) |=> $stable(en_q));

  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  a_r9_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> ($past(bus_wr) && $past(widx) == (ADDR_W-2)'(IDX_GENCFG)
                            && $past(bus_wdata[SELF_RST_BIT])));

  a_r10_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);
endmodule

bind bridge_ctrl_regs bcr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .sys_rst_req(sys_rst_req), .en_q(en_q)
);

// File: tb/bridge_ctrl_regs_tb.sv
module bridge_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        sys_rst_req;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bridge_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req)
  );

  typedef struct packed {
    logic [6:0]  wa;
    logic [31:0] wd;
    logic [6:0]  ra;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{7'h00, 32'hDEADBEEF, 7'h00, 32'hDEADBEEF},
    '{7'h44, 32'hA5A5A5A5, 7'h44, 32'hA5A5A5A5},
    '{7'h6C, 32'h00000000, 7'h6C, 32'h00000000},
    '{7'h1C, 32'hFFFFFFFF, 7'h1C, 32'hFFFFFFFF},
    '{7'h5F, 32'h13579BDF, 7'h5C, 32'h13579BDF},
    '{7'h3C, 32'h12345678, 7'h3C, 32'h00000000},
    '{7'h70, 32'hCAFEF00D, 7'h70, 32'h00000000},
    '{7'h7C, 32'h00000001, 7'h7C, 32'h00000000}
  };

  function automatic logic [31:0] rst_val(input int i);
    case (i)
      0: return 32'h00000C40;  1: return 32'h00001384;
      2: return 32'h2BFF8010;  3: return 32'h255E0091;
      4: return 32'h00006140;  7: return 32'h000001FF;
      8: return 32'h000001FF; 26: return 32'h00000008;
      27: return 32'h10000000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset values; R7: unimplemented offsets read 0
    for (int i = 0; i < 32; i++) begin
      rd(7'(i * 4), v);
      check(i < 28 ? "R2 reset value" : "R7 unknown read", v, rst_val(i));
    end
    check("R10 idle request", {31'b0, sys_rst_req}, 32'h0);

    // R1 R3 R6 R7: table of write/readback vectors
    for (int k = 0; k < 8; k++) begin
      wr(VEC[k].wa, VEC[k].wd);
      rd(VEC[k].ra, v);
      check("R1/R3/R6/R7 vector", v, VEC[k].exp);
    end
    // R7: unknown writes did not disturb word 0
    rd(7'h00, v);
    check("R7 no alias", v, 32'hDEADBEEF);

    // R4 R5 R6: set/clear aliases
    wr(7'h30, 32'h000000F0);
    rd(7'h38, v); check("R4 set", v, 32'h000000F0);
    wr(7'h30, 32'h00000F00);
    rd(7'h38, v); check("R4 or-in", v, 32'h00000FF0);
    rd(7'h30, v); check("R4 alias stored", v, 32'h00000F00);
    wr(7'h34, 32'h00000030);
    rd(7'h38, v); check("R5 clear", v, 32'h00000FC0);
    rd(7'h34, v); check("R5 alias stored", v, 32'h00000030);
    wr(7'h38, 32'hFFFFFFFF);
    rd(7'h38, v); check("R6 enable read-only", v, 32'h00000FC0);

    // R8: read and write same cycle return old value, then hold
    wr(7'h48, 32'h11111111);
    @(negedge clk);
    bus_addr = 7'h48; bus_wdata = 32'h22222222; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R8 read-before-write", bus_rdata, 32'h11111111);
    repeat (3) @(negedge clk);
    check("R8 hold", bus_rdata, 32'h11111111);
    rd(7'h48, v); check("R8 new value", v, 32'h22222222);

    // R9 R10: self-reset edge
    wr(7'h04, 32'h00001384);
    check("R9 no pulse when already set", {31'b0, sys_rst_req}, 32'h0);
    wr(7'h04, 32'h00001380);
    check("R9 no pulse on clear", {31'b0, sys_rst_req}, 32'h0);
    wr(7'h04, 32'h00001384);
    check("R9 pulse on rise", {31'b0, sys_rst_req}, 32'h1);
    @(negedge clk);
    check("R10 pulse one cycle", {31'b0, sys_rst_req}, 32'h0);
    rd(7'h04, v); check("R9 stored", v, 32'h00001384);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule